// File: doc/BRIEF.md
# Oscillator Control Register Bank

This block stores the programming state of a clock oscillator and hands the decoded fields to the oscillator datapath. A serial slave controller drives it through a byte port. It first loads a register pointer. It then issues read or write strobes, one data byte per strobe. Two of the registers are 16-bit words: the control word and the frequency DAC word. For these, a byte-phase flag steps the port from the high byte to the low byte after each access, so a two-byte burst needs only one pointer load.

The bank returns fixed ones and zeros in unused bit positions. It mirrors a 5-bit range value, taken from an input port, as a read-only register. It also uses that same value as the frequency offset until software writes the offset. A data-less write to the commit address raises a one-cycle pulse, which asks a storage controller outside this block to save the settings.

Top module: `osc_ctrl_regs`

## Requirements
- R1: After reset, the outputs hold these values: jit_rate_o=01, jit_pct_o=100, out_en_o=0, presc_o=0000, dac_o=500, wc_o=0, dev_addr_o=000. Control word bytes read 60h and 00h, DAC bytes read 7Dh and 00h, and the device byte reads F0h.
- R2: Control word at 02h. The high byte is {rate[1:0], pct[2:0], out_en, presc[3:2]} from bit 7 down to bit 0. The low byte holds presc[1:0] in bits 7:6, and its bits 5:0 read 0.
- R3: DAC word at 08h. The high byte holds dac[9:2]. The low byte holds dac[1:0] in bits 7:6, and its bits 5:0 read 0.
- R4: Offset at 0Eh. The register holds 5 bits in bits 4:0, and bits 7:5 read 1. Until the first write, offset_o follows range_i. After that write, offset_o keeps the written value and range_i no longer affects it.
- R5: Device byte at 0Dh. wc_o is bit 3 and dev_addr_o is bits 2:0. Bits 7:4 read 1, and writes to them have no effect.
- R6: Address 37h reads {000, range_i}. Writes to it change no output.
- R7: A ptr_load_i cycle loads the pointer from addr_i, clears the byte phase, and blocks any read or write strobe in that cycle. Each rd_i or wr_i strobe at 02h or 08h toggles the byte phase. The phase stays at the high byte for every other address.
- R8: A write at 3Fh raises commit_o on the next cycle, for exactly one cycle per write strobe. This write changes no register, and 3Fh reads 00h.
- R9: Every other address reads 00h, and writes to these addresses change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ptr_load_i | input | 1 | Load register pointer from addr_i |
| addr_i | input | 8 | Pointer value |
| rd_i | input | 1 | Read strobe, advances byte phase |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write byte |
| rdata_o | output | 8 | Read byte at current pointer and phase |
| range_i | input | 5 | Factory range value |
| jit_rate_o | output | 2 | Dither rate select |
| jit_pct_o | output | 3 | Dither depth select |
| out_en_o | output | 1 | Output drive control bit |
| presc_o | output | 4 | Prescaler exponent |
| dac_o | output | 10 | Frequency DAC word |
| offset_o | output | 5 | Effective offset |
| wc_o | output | 1 | Write-control bit |
| dev_addr_o | output | 3 | Device address bits |
| commit_o | output | 1 | Commit-to-storage pulse |

## Verification
The assertions assume that the controller asserts a strobe for one cycle per byte, and that rd_i and wr_i are never high in the same cycle. They also assume that range_i changes only between accesses, since offset_o is excluded from the stability checks. The bench drives one strobe or one pointer load per cycle, on the falling edge. The one exception is a deliberate cycle in which a pointer load and a write coincide, which tests that the load takes precedence.

// File: rtl/osc_regs_pkg.sv
package osc_regs_pkg;
  localparam int DW    = 8;
  localparam int AW    = 8;
  localparam int DAC_W = 10;
  localparam int OFS_W = 5;
  localparam int PRE_W = 4;
  localparam int JS_W  = 5;
  localparam int DEV_W = 3;
  localparam int DAC_LO = DAC_W - DW;   // bits carried in the low byte

  localparam logic [AW-1:0] A_CTRL = 8'h02;
  localparam logic [AW-1:0] A_DAC  = 8'h08;
  localparam logic [AW-1:0] A_DEV  = 8'h0D;
  localparam logic [AW-1:0] A_OFS  = 8'h0E;
  localparam logic [AW-1:0] A_RNG  = 8'h37;
  localparam logic [AW-1:0] A_CMT  = 8'h3F;

  typedef struct packed {
    logic [JS_W-1:0]  js;
    logic             out_en;
    logic [PRE_W-1:0] presc;
    logic [DAC_W-1:0] dac;
    logic             ofs_set;
    logic [OFS_W-1:0] ofs;
    logic             wc;
    logic [DEV_W-1:0] dev;
  } regs_t;

  localparam regs_t REGS_RST = '{js: 5'b01100, out_en: 1'b0, presc: '0,
                                 dac: 10'd500, ofs_set: 1'b0, ofs: '0,
                                 wc: 1'b0, dev: '0};

  function automatic logic is_word(input logic [AW-1:0] a);
    return (a == A_CTRL) || (a == A_DAC);
  endfunction
endpackage

// File: rtl/osc_ptr.sv
module osc_ptr
  import osc_regs_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] addr_i,
  input  logic          acc_i,
  output logic [AW-1:0] ptr_o,
  output logic          phase_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_o   <= '0;
      phase_o <= 1'b0;
    end else if (load_i) begin
      ptr_o   <= addr_i;
      phase_o <= 1'b0;
    end else if (acc_i && is_word(ptr_o)) begin
      phase_o <= ~phase_o;
    end
  end
endmodule

// File: rtl/osc_regfile.sv
module osc_regfile
  import osc_regs_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    ptr_i,
  input  logic             phase_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [OFS_W-1:0] range_i,
  output regs_t            regs_o,
  output logic [OFS_W-1:0] ofs_eff_o,
  output logic             commit_o
);
  regs_t r_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_q      <= REGS_RST;
      commit_o <= 1'b0;
    end else begin
      commit_o <= wr_en_i && (ptr_i == A_CMT);
      if (wr_en_i) begin
        unique case (ptr_i)
          A_CTRL: begin
            if (!phase_i) {r_q.js, r_q.out_en, r_q.presc[PRE_W-1:2]} <= wdata_i;
            else          r_q.presc[1:0] <= wdata_i[DW-1 -: 2];
          end
          A_DAC: begin
            if (!phase_i) r_q.dac[DAC_W-1 -: DW] <= wdata_i;
            else          r_q.dac[DAC_LO-1:0]    <= wdata_i[DW-1 -: DAC_LO];
          end
          A_OFS: begin
            r_q.ofs     <= wdata_i[OFS_W-1:0];
            r_q.ofs_set <= 1'b1;
          end
          A_DEV:   {r_q.wc, r_q.dev} <= wdata_i[DEV_W:0];
          default: ;
        endcase
      end
    end
  end

  assign regs_o    = r_q;
  assign ofs_eff_o = r_q.ofs_set ? r_q.ofs : range_i;
endmodule

// File: rtl/osc_rd_mux.sv
module osc_rd_mux
  import osc_regs_pkg::*;
(
  input  logic [AW-1:0]    ptr_i,
  input  logic             phase_i,
  input  regs_t            regs_i,
  input  logic [OFS_W-1:0] ofs_eff_i,
  input  logic [OFS_W-1:0] range_i,
  output logic [DW-1:0]    rdata_o
);
  always_comb begin
    rdata_o = '0;
    unique case (ptr_i)
      A_CTRL: rdata_o = phase_i ? {regs_i.presc[1:0], 6'b0}
                                : {regs_i.js, regs_i.out_en, regs_i.presc[PRE_W-1:2]};
      A_DAC:  rdata_o = phase_i ? {regs_i.dac[DAC_LO-1:0], {(DW-DAC_LO){1'b0}}}
                                : regs_i.dac[DAC_W-1 -: DW];
      A_OFS:  rdata_o = {{(DW-OFS_W){1'b1}}, ofs_eff_i};
      A_DEV:  rdata_o = {{(DW-DEV_W-1){1'b1}}, regs_i.wc, regs_i.dev};
      A_RNG:  rdata_o = {{(DW-OFS_W){1'b0}}, range_i};
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/osc_ctrl_regs.sv
module osc_ctrl_regs
  import osc_regs_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ptr_load_i,
  input  logic [AW-1:0]    addr_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  input  logic [OFS_W-1:0] range_i,
  output logic [1:0]       jit_rate_o,
  output logic [2:0]       jit_pct_o,
  output logic             out_en_o,
  output logic [PRE_W-1:0] presc_o,
  output logic [DAC_W-1:0] dac_o,
  output logic [OFS_W-1:0] offset_o,
  output logic             wc_o,
  output logic [DEV_W-1:0] dev_addr_o,
  output logic             commit_o
);
  logic [AW-1:0]    ptr_q;
  logic             phase_q;
  regs_t            regs;
  logic [OFS_W-1:0] ofs_eff;
  logic             wr_en;

  assign wr_en = wr_i && !ptr_load_i;

  osc_ptr u_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (ptr_load_i),
    .addr_i  (addr_i),
    .acc_i   (rd_i || wr_i),
    .ptr_o   (ptr_q),
    .phase_o (phase_q)
  );

  osc_regfile u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .ptr_i     (ptr_q),
    .phase_i   (phase_q),
    .wdata_i   (wdata_i),
    .range_i   (range_i),
    .regs_o    (regs),
    .ofs_eff_o (ofs_eff),
    .commit_o  (commit_o)
  );

  osc_rd_mux u_rd (
    .ptr_i     (ptr_q),
    .phase_i   (phase_q),
    .regs_i    (regs),
    .ofs_eff_i (ofs_eff),
    .range_i   (range_i),
    .rdata_o   (rdata_o)
  );

  assign jit_rate_o = regs.js[JS_W-1 -: 2];
  assign jit_pct_o  = regs.js[2:0];
  assign out_en_o   = regs.out_en;
  assign presc_o    = regs.presc;
  assign dac_o      = regs.dac;
  assign offset_o   = ofs_eff;
  assign wc_o       = regs.wc;
  assign dev_addr_o = regs.dev;
endmodule

// File: rtl/osc_ctrl_regs_chk.sv
module osc_ctrl_regs_chk
  import osc_regs_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ptr_load_i,
  input logic             rd_i,
  input logic             wr_i,
  input logic [DW-1:0]    rdata_o,
  input logic [AW-1:0]    ptr_q,
  input logic             phase_q,
  input logic [DAC_W-1:0] dac_o,
  input logic [PRE_W-1:0] presc_o,
  input logic [1:0]       jit_rate_o,
  input logic [2:0]       jit_pct_o,
  input logic             out_en_o,
  input logic             wc_o,
  input logic [DEV_W-1:0] dev_addr_o,
  input logic             commit_o
);
  logic wr_ok, defined;
  assign wr_ok   = wr_i && !ptr_load_i;
  assign defined = (ptr_q == A_CTRL) || (ptr_q == A_DAC) || (ptr_q == A_DEV) ||
                   (ptr_q == A_OFS) || (ptr_q == A_RNG) || (ptr_q == A_CMT);

  AST_COMMIT_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> $past(wr_ok && ptr_q == A_CMT));  // R8
  AST_COMMIT_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok && ptr_q == A_CMT) |=> ($stable(dac_o) && $stable(presc_o) && $stable(jit_rate_o)
      && $stable(jit_pct_o) && $stable(out_en_o) && $stable(wc_o) && $stable(dev_addr_o)));  // R8
  AST_RANGE_RO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok && ptr_q == A_RNG) |=> ($stable(dac_o) && $stable(presc_o) && $stable(jit_rate_o)
      && $stable(jit_pct_o) && $stable(out_en_o) && $stable(wc_o) && $stable(dev_addr_o)));  // R6
  AST_UNDEF_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok && !defined) |=> ($stable(dac_o) && $stable(presc_o) && $stable(jit_rate_o)
      && $stable(wc_o) && $stable(dev_addr_o)));  // R9
  AST_UNDEF_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !defined |-> rdata_o == '0);  // R9
  AST_PHASE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ptr_load_i && (rd_i || wr_i) && is_word(ptr_q)) |=> phase_q != $past(phase_q));  // R7
  AST_LOAD_CLEARS_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_load_i |=> !phase_q);  // R7
  AST_DAC_PAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_q == A_DAC && phase_q) |-> rdata_o[5:0] == '0);  // R3
  AST_OFS_PAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_q == A_OFS) |-> rdata_o[7:5] == 3'b111);  // R4
  AST_DEV_PAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_q == A_DEV) |-> rdata_o[7:4] == 4'hF);  // R5
endmodule

bind osc_ctrl_regs osc_ctrl_regs_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ptr_load_i (ptr_load_i),
  .rd_i       (rd_i),
  .wr_i       (wr_i),
  .rdata_o    (rdata_o),
  .ptr_q      (ptr_q),
  .phase_q    (phase_q),
  .dac_o      (dac_o),
  .presc_o    (presc_o),
  .jit_rate_o (jit_rate_o),
  .jit_pct_o  (jit_pct_o),
  .out_en_o   (out_en_o),
  .wc_o       (wc_o),
  .dev_addr_o (dev_addr_o),
  .commit_o   (commit_o)
);

// File: tb/osc_ctrl_regs_bench.sv
`timescale 1ns/1ps
module osc_ctrl_regs_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ptr_load_i = 1'b0, rd_i = 1'b0, wr_i = 1'b0;
  logic [7:0] addr_i = '0, wdata_i = '0, rdata_o;
  logic [4:0] range_i = 5'h0A;
  logic [1:0] jit_rate_o;
  logic [2:0] jit_pct_o;
  logic       out_en_o, wc_o, commit_o;
  logic [3:0] presc_o;
  logic [9:0] dac_o;
  logic [4:0] offset_o;
  logic [2:0] dev_addr_o;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  osc_ctrl_regs u_osc_ctrl_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .ptr_load_i(ptr_load_i), .addr_i(addr_i),
    .rd_i(rd_i), .wr_i(wr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .range_i(range_i), .jit_rate_o(jit_rate_o), .jit_pct_o(jit_pct_o),
    .out_en_o(out_en_o), .presc_o(presc_o), .dac_o(dac_o), .offset_o(offset_o),
    .wc_o(wc_o), .dev_addr_o(dev_addr_o), .commit_o(commit_o)
  );

  // {addr, wbyte0, wbyte1, rexp0, rexp1}
  localparam logic [39:0] VEC [7] = '{
    {8'h02, 8'hA5, 8'hFF, 8'hA5, 8'hC0},   // R2
    {8'h08, 8'h12, 8'h80, 8'h12, 8'h80},   // R3
    {8'h0E, 8'h00, 8'h0D, 8'hED, 8'hED},   // R4
    {8'h0D, 8'h3A, 8'h05, 8'hF5, 8'hF5},   // R5
    {8'h37, 8'hFF, 8'hFF, 8'h13, 8'h13},   // R6
    {8'h3F, 8'h77, 8'h77, 8'h00, 8'h00},   // R8
    {8'h55, 8'hAA, 8'hBB, 8'h00, 8'h00}    // R9
  };

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_load(input logic [7:0] a);
    ptr_load_i = 1'b1; addr_i = a;
    @(negedge clk_i);
    ptr_load_i = 1'b0;
  endtask

  task automatic do_wr(input logic [7:0] d);
    wr_i = 1'b1; wdata_i = d;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic do_rd(input logic [7:0] exp, input string tag);
    chk({8'h0, rdata_o}, {8'h0, exp}, tag);
    rd_i = 1'b1;
    @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // reset state
    chk({6'b0, dac_o}, 16'd500, "R1 dac_o");
    chk({jit_rate_o, jit_pct_o, out_en_o, presc_o}, {5'b0, 2'b01, 3'b100, 1'b0, 4'b0000}, "R1 ctrl fields");
    chk({wc_o, dev_addr_o}, 4'h0, "R1 dev fields");
    chk({11'b0, offset_o}, 16'h0A, "R4 offset follows range");
    do_load(8'h02); do_rd(8'h60, "R1 ctrl hi"); do_rd(8'h00, "R1 ctrl lo");
    do_rd(8'h60, "R7 phase wraps");
    do_load(8'h08); do_rd(8'h7D, "R1 dac hi"); do_rd(8'h00, "R1 dac lo");
    do_load(8'h0D); do_rd(8'hF0, "R1 dev byte");
    do_load(8'h0E); do_rd(8'hEA, "R4 offset read");
    range_i = 5'h13;
    @(negedge clk_i);
    chk({11'b0, offset_o}, 16'h13, "R4 offset tracks range");

    // table walk: write two bytes, reload, read two bytes
    for (int i = 0; i < 7; i++) begin
      do_load(VEC[i][39:32]);
      do_wr(VEC[i][31:24]);
      do_wr(VEC[i][23:16]);
      do_load(VEC[i][39:32]);
      do_rd(VEC[i][15:8], $sformatf("vec%0d byte0", i));
      do_rd(VEC[i][7:0],  $sformatf("vec%0d byte1", i));
    end

    // decoded fields after the table (also proves 37h/3Fh/55h writes were ignored)
    chk({jit_rate_o, jit_pct_o, out_en_o, presc_o}, {5'b0, 2'b10, 3'b100, 1'b1, 4'b0111}, "R2 ctrl fields");
    chk({6'b0, dac_o}, 16'd74, "R3 dac_o");
    chk({wc_o, dev_addr_o}, 4'h5, "R5 dev fields");
    chk({11'b0, offset_o}, 16'h0D, "R4 offset written");
    range_i = 5'h04;
    @(negedge clk_i);
    chk({11'b0, offset_o}, 16'h0D, "R4 offset ignores range");
    do_load(8'h37); do_rd(8'h04, "R6 range mirror");

    // commit pulse
    chk({15'b0, commit_o}, 16'h0, "R8 commit idle");
    do_load(8'h3F);
    do_wr(8'h00);
    chk({15'b0, commit_o}, 16'h1, "R8 commit pulse");
    @(negedge clk_i);
    chk({15'b0, commit_o}, 16'h0, "R8 commit single cycle");
    chk({6'b0, dac_o}, 16'd74, "R8 dac unchanged");

    // write in the load cycle is ignored
    ptr_load_i = 1'b1; addr_i = 8'h08; wr_i = 1'b1; wdata_i = 8'hFF;
    @(negedge clk_i);
    ptr_load_i = 1'b0; wr_i = 1'b0;
    chk({6'b0, dac_o}, 16'd74, "R7 load blocks write");
    do_rd(8'h12, "R7 phase cleared on load");
    do_wr(8'hC0);
    chk({6'b0, dac_o}, 16'd75, "R3 low byte write");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(negedge clk_i);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule